// File: doc/BRIEF.md
# Serial programming target command interface

This block is the target end of a four-byte serial programming link. A host drives a serial clock and a data line. The target returns one reply bit per clock on its data output. Every frame is four bytes long. The block runs on the chip clock. It resynchronizes the serial clock, the serial data and a select line, and it finds the serial clock edges by oversampling them. While the select line is low, the block counts bits into frames. A frame takes effect only once all 32 bits have arrived.

Programming mode opens with a fixed two-byte signature. While that signature goes out, the target echoes back the second signature byte, so the host can confirm that both ends agree on byte alignment. Once in programming mode, the host fills a 64-word page buffer one byte at a time, low half first and then high half. A page-write command then commits the buffer to the memory side. The commit is a one-cycle strobe that carries a 7-bit page number, the buffer contents and a mask of the words that are complete. The memory model writes only the masked words. A poll command reports the memory side's busy flag to the host. Raising the select line aborts a partial frame and closes programming mode.

Top module: `sprog_target`

## Requirements
- R1: On each rising edge of `sclk`, one bit of `sdi` is taken in, most significant bit first. `sdo` changes only after a rising edge, so the host reads reply bit k at the falling edge that follows the k-th rising edge. Reply bits also go out most significant bit first.
- R2: For each frame, the reply for byte 0 is 0x00. The reply for byte n (n = 1, 2, 3) is the byte received in position n-1. As a result, 0x53 is echoed during the third byte of the enable command.
- R3: A command takes effect only after its 32nd bit. A frame cut short by the select line has no effect.
- R4: A frame with byte 0 = 0xAC and byte 1 = 0x53 enters programming mode. Outside programming mode, every other frame changes neither the buffer nor `pg_we`.
- R5: Load-low (byte 0 = 0x40) writes byte 3 into the low half of the buffer word chosen by byte 2 bits [5:0]. Byte 1 and byte 2 bits [7:6] are ignored.
- R6: Load-high (byte 0 = 0x48) uses the same word selection as load-low. It writes byte 3 into the high half and marks the word complete only if that word's low half was loaded since the last commit. Otherwise it is ignored.
- R7: Write-page (byte 0 = 0x4C) raises `pg_we` for exactly one cycle. With A = {byte1, byte2}, `pg_num` = A[12:6]. `pg_mask` bit i is set for each word i that is complete. `pg_data[16i+15:16i]` = {high, low} of word i.
- R8: A commit clears all low-loaded and complete marks, so the next commit reports only words loaded after it.
- R9: Poll (byte 0 = 0xF0) in programming mode returns {7'b0, mem_busy} as the fourth reply byte. `mem_busy` is sampled when byte 2 completes.
- R10: While `prog_sel_n` is high, the bit counter holds at zero, programming mode is closed and `sdo` is 0. The first frame after the select line goes low is aligned from bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Chip clock; oversamples the serial link |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_sel_n | input | 1 | Link select; low enables framing, high resets alignment and mode |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial reply data to the host |
| mem_busy | input | 1 | Busy flag from the memory side |
| pg_we | output | 1 | One-cycle page commit strobe |
| pg_num | output | 7 | Page number of the commit |
| pg_mask | output | 64 | Complete-word mask of the commit |
| pg_data | output | 1024 | Buffer contents, word i at bits [16i+15:16i] |

## Verification
The buffer is filled over all 64 word indices with an arithmetic data pattern and committed. This separates index decoding from half ordering, because every word and both halves carry distinct values. An even-only load, with garbage in the ignored address bits and an extreme page number, separates mask generation and page extraction from address aliasing. A high-before-low sequence, a low-only load, and a reload after a commit tell the low-loaded mark apart from the complete mark, and show that both are cleared. Replies are compared in every frame position, including the enable echo and a poll with the busy flag at each value. A frame cut off by the select line, followed by a fresh enable, shows that a partial frame leaves no trace and that alignment is restored.

// File: rtl/sprog_pkg.sv
package sprog_pkg;
  localparam logic [7:0] OP_EN0  = 8'hAC;
  localparam logic [7:0] OP_EN1  = 8'h53;
  localparam logic [7:0] OP_LDLO = 8'h40;
  localparam logic [7:0] OP_LDHI = 8'h48;
  localparam logic [7:0] OP_WRPG = 8'h4C;
  localparam logic [7:0] OP_POLL = 8'hF0;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_LDLO   = 2'd1,
    ACT_LDHI   = 2'd2,
    ACT_COMMIT = 2'd3
  } act_e;
endpackage

// File: rtl/sprog_sync.sv
module sprog_sync #(
  parameter int           W   = 1,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= RST;
      q    <= RST;
    end else begin
      s1_q <= d;
      q    <= s1_q;
    end
  end
endmodule

// File: rtl/sprog_link.sv
module sprog_link
  import sprog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk_s,
  input  logic       sdi_s,
  input  logic       idle,
  input  logic       prog_on,
  input  logic       busy,
  output logic       sdo,
  output logic       frame_done,
  output logic [7:0] cmd0,
  output logic [7:0] cmd1,
  output logic [7:0] cmd2,
  output logic [7:0] cmd3
);
  logic       sclk_q;
  logic [4:0] cnt_q, cnt_n;
  logic [7:0] rx_q, rx_n;
  logic [7:0] tx_q, tx_n;
  logic [7:0] c0_n, c1_n, c2_n, c3_n;
  logic       sdo_n, done_n;
  logic       rise, byte_end;
  logic [7:0] rxb, reply;

  assign rise     = sclk_s & ~sclk_q;
  assign rxb      = {rx_q[6:0], sdi_s};
  assign byte_end = (cnt_q[2:0] == 3'd7);

  // reply for the byte that follows the one just completed
  always_comb begin
    case (cnt_q[4:3])
      2'd2:    reply = (prog_on && cmd0 == OP_POLL) ? {7'b0, busy} : rxb;
      2'd3:    reply = 8'h00;
      default: reply = rxb;
    endcase
  end

  always_comb begin
    cnt_n  = cnt_q;
    rx_n   = rx_q;
    tx_n   = tx_q;
    sdo_n  = sdo;
    done_n = 1'b0;
    c0_n   = cmd0;
    c1_n   = cmd1;
    c2_n   = cmd2;
    c3_n   = cmd3;
    if (idle) begin
      cnt_n = '0;
      tx_n  = '0;
      sdo_n = 1'b0;
    end else if (rise) begin
      rx_n  = rxb;
      cnt_n = cnt_q + 5'd1;
      sdo_n = tx_q[7];
      tx_n  = byte_end ? reply : {tx_q[6:0], 1'b0};
      if (byte_end) begin
        case (cnt_q[4:3])
          2'd0: c0_n = rxb;
          2'd1: c1_n = rxb;
          2'd2: c2_n = rxb;
          default: begin
            c3_n   = rxb;
            done_n = 1'b1;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q     <= 1'b0;
      cnt_q      <= '0;
      tx_q       <= '0;
      sdo        <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      sclk_q     <= sclk_s;
      cnt_q      <= cnt_n;
      tx_q       <= tx_n;
      sdo        <= sdo_n;
      frame_done <= done_n;
    end
  end

  always_ff @(posedge clk) begin
    rx_q <= rx_n;
    cmd0 <= c0_n;
    cmd1 <= c1_n;
    cmd2 <= c2_n;
    cmd3 <= c3_n;
  end

  // R1: each detected serial rising edge advances the bit position by one
  p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !idle) |=> (cnt_q == $past(cnt_q) + 5'd1));

  // R10: select high realigns the counter and silences the reply line
  p_idle_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> (cnt_q == 5'd0 && !sdo));

  // R3: a frame is reported only once the counter has wrapped after 32 bits
  p_done_at_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (cnt_q == 5'd0));
endmodule

// File: rtl/sprog_ctrl.sv
module sprog_ctrl
  import sprog_pkg::*;
#(
  parameter int IDXW = 6,
  parameter int PGW  = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            idle,
  input  logic            frame_done,
  input  logic [7:0]      cmd0,
  input  logic [7:0]      cmd1,
  input  logic [7:0]      cmd2,
  input  logic [7:0]      cmd3,
  output logic            prog_on,
  output act_e            act,
  output logic [IDXW-1:0] idx,
  output logic [7:0]      dat,
  output logic [PGW-1:0]  page
);
  localparam int AW = IDXW + PGW;

  logic [15:0]     addr;
  logic            unused_hi;
  logic            on_n;
  act_e            act_n;
  logic [IDXW-1:0] idx_n;
  logic [7:0]      dat_n;
  logic [PGW-1:0]  page_n;
  logic            is_enable;

  assign addr      = {cmd1, cmd2};
  assign unused_hi = ^addr[15:AW];
  assign is_enable = (cmd0 == OP_EN0) && (cmd1 == OP_EN1);

  always_comb begin
    on_n   = prog_on;
    act_n  = ACT_NONE;
    idx_n  = idx;
    dat_n  = dat;
    page_n = page;
    if (idle) begin
      on_n = 1'b0;
    end else if (frame_done) begin
      if (is_enable) begin
        on_n = 1'b1;
      end else if (prog_on) begin
        idx_n  = cmd2[IDXW-1:0];
        dat_n  = cmd3;
        page_n = addr[AW-1:IDXW];
        case (cmd0)
          OP_LDLO: act_n = ACT_LDLO;
          OP_LDHI: act_n = ACT_LDHI;
          OP_WRPG: act_n = ACT_COMMIT;
          default: act_n = ACT_NONE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_on <= 1'b0;
      act     <= ACT_NONE;
    end else begin
      prog_on <= on_n;
      act     <= act_n;
    end
  end

  always_ff @(posedge clk) begin
    idx  <= idx_n;
    dat  <= dat_n;
    page <= page_n;
  end

  // R4: no buffer action unless programming mode was already open
  p_act_in_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (act != ACT_NONE) |-> $past(prog_on));

  // R4: a complete signature frame opens programming mode
  p_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !idle && is_enable) |=> prog_on);
endmodule

// File: rtl/sprog_pagebuf.sv
module sprog_pagebuf
  import sprog_pkg::*;
#(
  parameter int WORDS = 64,
  parameter int PGW   = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  act_e                  act,
  input  logic [$clog2(WORDS)-1:0] idx,
  input  logic [7:0]            dat,
  input  logic [PGW-1:0]        page,
  output logic                  pg_we,
  output logic [PGW-1:0]        pg_num,
  output logic [WORDS-1:0]      pg_mask,
  output logic [WORDS*16-1:0]   pg_data
);
  logic [WORDS-1:0] sel, wr_lo, wr_hi;
  logic [WORDS-1:0] lo_seen_q, lo_seen_n;
  logic [WORDS-1:0] vld_q, vld_n;
  logic             commit;

  assign commit = (act == ACT_COMMIT);

  always_comb begin
    sel      = '0;
    sel[idx] = 1'b1;
    wr_lo    = (act == ACT_LDLO) ? sel : '0;
    wr_hi    = (act == ACT_LDHI) ? (sel & lo_seen_q) : '0;
    if (commit) begin
      lo_seen_n = '0;
      vld_n     = '0;
    end else begin
      lo_seen_n = lo_seen_q | wr_lo;
      vld_n     = vld_q | wr_hi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_seen_q <= '0;
      vld_q     <= '0;
      pg_we     <= 1'b0;
    end else begin
      lo_seen_q <= lo_seen_n;
      vld_q     <= vld_n;
      pg_we     <= commit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_num  <= '0;
      pg_mask <= '0;
    end else if (commit) begin
      pg_num  <= page;
      pg_mask <= vld_q;
    end
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic [7:0] lo_q, hi_q;
    always_ff @(posedge clk) begin
      if (wr_lo[g]) lo_q <= dat;
      if (wr_hi[g]) hi_q <= dat;
    end
    assign pg_data[16*g +: 16] = {hi_q, lo_q};
  end

  // R7: the commit strobe lasts a single cycle
  p_we_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pg_we |=> !pg_we);

  // R8: marks are empty in the cycle the strobe is visible
  p_commit_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pg_we |-> (vld_q == '0 && lo_seen_q == '0));

  // R6: a word is never complete without its low half marked
  p_mask_needs_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> ((vld_q & ~lo_seen_q) == '0));
endmodule

// File: rtl/sprog_target.sv
module sprog_target
  import sprog_pkg::*;
#(
  parameter int WORDS = 64,
  parameter int PGW   = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                prog_sel_n,
  input  logic                sclk,
  input  logic                sdi,
  output logic                sdo,
  input  logic                mem_busy,
  output logic                pg_we,
  output logic [PGW-1:0]      pg_num,
  output logic [WORDS-1:0]    pg_mask,
  output logic [WORDS*16-1:0] pg_data
);
  localparam int IDXW = $clog2(WORDS);

  logic [2:0]      sync_q;
  logic            idle, sclk_s, sdi_s;
  logic            frame_done, prog_on;
  logic [7:0]      cmd0, cmd1, cmd2, cmd3;
  act_e            act;
  logic [IDXW-1:0] idx;
  logic [7:0]      dat;
  logic [PGW-1:0]  page;

  sprog_sync #(.W(3), .RST(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({prog_sel_n, sclk, sdi}),
    .q     (sync_q)
  );

  assign idle   = sync_q[2];
  assign sclk_s = sync_q[1];
  assign sdi_s  = sync_q[0];

  sprog_link u_link (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk_s     (sclk_s),
    .sdi_s      (sdi_s),
    .idle       (idle),
    .prog_on    (prog_on),
    .busy       (mem_busy),
    .sdo        (sdo),
    .frame_done (frame_done),
    .cmd0       (cmd0),
    .cmd1       (cmd1),
    .cmd2       (cmd2),
    .cmd3       (cmd3)
  );

  sprog_ctrl #(.IDXW(IDXW), .PGW(PGW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .idle       (idle),
    .frame_done (frame_done),
    .cmd0       (cmd0),
    .cmd1       (cmd1),
    .cmd2       (cmd2),
    .cmd3       (cmd3),
    .prog_on    (prog_on),
    .act        (act),
    .idx        (idx),
    .dat        (dat),
    .page       (page)
  );

  sprog_pagebuf #(.WORDS(WORDS), .PGW(PGW)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .act     (act),
    .idx     (idx),
    .dat     (dat),
    .page    (page),
    .pg_we   (pg_we),
    .pg_num  (pg_num),
    .pg_mask (pg_mask),
    .pg_data (pg_data)
  );

  // R10: closing the select line closes programming mode
  p_sel_closes_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> !prog_on);
endmodule

// File: tb/sprog_target_bench.sv
`timescale 1ns/1ps
module sprog_target_bench;
  logic          clk = 1'b0;
  logic          rst_n, prog_sel_n, sclk, sdi, mem_busy;
  logic          sdo, pg_we;
  logic [6:0]    pg_num;
  logic [63:0]   pg_mask;
  logic [1023:0] pg_data;

  int n_run = 0, n_fail = 0, we_cnt = 0;
  logic [6:0]    cap_num;
  logic [63:0]   cap_mask;
  logic [1023:0] cap_data;

  always #5 clk = ~clk;

  sprog_target u_sprog_target (
    .clk(clk), .rst_n(rst_n), .prog_sel_n(prog_sel_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .mem_busy(mem_busy), .pg_we(pg_we), .pg_num(pg_num),
    .pg_mask(pg_mask), .pg_data(pg_data)
  );

  always @(posedge clk) begin
    if (pg_we) begin
      we_cnt   <= we_cnt + 1;
      cap_num  <= pg_num;
      cap_mask <= pg_mask;
      cap_data <= pg_data;
    end
  end

  function automatic logic [7:0] lo_a(int i); return 8'(i * 3 + 17); endfunction
  function automatic logic [7:0] hi_a(int i); return 8'(i) ^ 8'hA5; endfunction
  function automatic logic [7:0] lo_b(int i); return 8'(i * 7 + 1); endfunction
  function automatic logic [7:0] hi_b(int i); return 8'(255 - i); endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] f, input int nb, output logic [31:0] r);
    r = '0;
    for (int i = 31; i >= 32 - nb; i--) begin
      sdi = f[i];
      #70;
      sclk = 1'b1;
      #70;
      r[i] = sdo;
      sclk = 1'b0;
    end
    sdi = 1'b0;
    #150;
  endtask

  task automatic frame(input logic [7:0] a, b, c, d, output logic [31:0] r);
    xfer({a, b, c, d}, 32, r);
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int w0;
    int bad;
    rst_n = 1'b0; prog_sel_n = 1'b1; sclk = 1'b0; sdi = 1'b0; mem_busy = 1'b0;
    #53;
    chk("R10 reset sdo", 64'(sdo), 64'd0);
    chk("R7 reset pg_we", 64'(pg_we), 64'd0);
    rst_n = 1'b1;
    #50;
    prog_sel_n = 1'b0;
    #100;

    // R4: commands before enable do nothing
    w0 = we_cnt;
    frame(8'h40, 8'h00, 8'h00, 8'h12, r);
    frame(8'h48, 8'h00, 8'h00, 8'h34, r);
    frame(8'h4C, 8'h00, 8'h80, 8'h00, r);
    chk("R4 no strobe before enable", 64'(we_cnt), 64'(w0));

    // R2/R4: wrong second byte, no echo of 0x53, no mode
    frame(8'hAC, 8'h00, 8'h00, 8'h00, r);
    chk("R2 bad enable reply byte2", 64'(r[15:8]), 64'h00);
    frame(8'h4C, 8'h00, 8'h80, 8'h00, r);
    chk("R4 bad enable keeps mode closed", 64'(we_cnt), 64'(w0));

    // R2/R1: enable echo
    frame(8'hAC, 8'h53, 8'h00, 8'h00, r);
    chk("R2 enable reply byte0", 64'(r[31:24]), 64'h00);
    chk("R1 enable reply byte1", 64'(r[23:16]), 64'hAC);
    chk("R2 enable echo 0x53", 64'(r[15:8]), 64'h53);

    // R5/R6/R7: full sweep of the buffer
    bad = 0;
    for (int i = 0; i < 64; i++) begin
      frame(8'h40, 8'h00, 8'(i), lo_a(i), r);
      if (r !== {8'h00, 8'h40, 8'h00, 8'(i)}) bad++;
      frame(8'h48, 8'h00, 8'(i), hi_a(i), r);
    end
    chk("R2 echo during sweep", 64'(bad), 64'd0);
    w0 = we_cnt;
    frame(8'h4C, 8'h01, 8'h40, 8'h00, r);
    chk("R7 one strobe", 64'(we_cnt), 64'(w0 + 1));
    chk("R7 page number 5", 64'(cap_num), 64'd5);
    chk("R7 full mask", cap_mask, 64'hFFFF_FFFF_FFFF_FFFF);
    for (int i = 0; i < 64; i++)
      chk($sformatf("R5 R6 word %0d data", i), 64'(cap_data[16*i +: 16]), 64'({hi_a(i), lo_a(i)}));

    // R8: commit with no loads reports empty mask
    frame(8'h4C, 8'h00, 8'h00, 8'h00, r);
    chk("R8 mask empty after commit", cap_mask, 64'd0);
    chk("R7 page 0", 64'(cap_num), 64'd0);

    // R5: even words, junk in ignored address bits; R7: page 127
    for (int i = 0; i < 64; i += 2) begin
      frame(8'h40, 8'h3F, 8'(i) | 8'hC0, lo_b(i), r);
      frame(8'h48, 8'hE5, 8'(i) | 8'h80, hi_b(i), r);
    end
    frame(8'h4C, 8'h1F, 8'hC0, 8'h00, r);
    chk("R7 page 127", 64'(cap_num), 64'd127);
    chk("R7 even mask", cap_mask, 64'h5555_5555_5555_5555);
    for (int i = 0; i < 64; i += 2)
      chk($sformatf("R5 even word %0d", i), 64'(cap_data[16*i +: 16]), 64'({hi_b(i), lo_b(i)}));
    chk("R5 odd word 1 kept", 64'(cap_data[31:16]), 64'({hi_a(1), lo_a(1)}));

    // R6: ordering of halves
    frame(8'h48, 8'h00, 8'd3, 8'h77, r);
    frame(8'h40, 8'h00, 8'd4, 8'h66, r);
    frame(8'h40, 8'h00, 8'd7, 8'h5A, r);
    frame(8'h48, 8'h00, 8'd7, 8'hC3, r);
    frame(8'h4C, 8'h00, 8'h40, 8'h00, r);
    chk("R6 only word 7 complete", cap_mask, 64'h80);
    chk("R6 word 7 data", 64'(cap_data[127:112]), 64'hC35A);
    chk("R6 high-only word 3 ignored", 64'(cap_data[63:48]), 64'({hi_a(3), lo_a(3)}));
    chk("R7 page 1", 64'(cap_num), 64'd1);
    frame(8'h48, 8'h00, 8'd4, 8'h99, r);
    frame(8'h4C, 8'h00, 8'h40, 8'h00, r);
    chk("R8 low mark cleared by commit", cap_mask, 64'd0);

    // R9: poll
    mem_busy = 1'b1;
    frame(8'hF0, 8'h00, 8'h00, 8'h00, r);
    chk("R9 poll busy", 64'(r[7:0]), 64'h01);
    mem_busy = 1'b0;
    frame(8'hF0, 8'h00, 8'h00, 8'h00, r);
    chk("R9 poll ready", 64'(r[7:0]), 64'h00);
    frame(8'h40, 8'h00, 8'h2A, 8'h00, r);
    chk("R2 non-poll fourth reply", 64'(r[7:0]), 64'h2A);

    // R3/R10: partial frame then realign
    xfer({8'h40, 8'h00, 8'd9, 8'h11}, 20, r);
    prog_sel_n = 1'b1;
    #200;
    chk("R10 sdo idle", 64'(sdo), 64'd0);
    prog_sel_n = 1'b0;
    #200;
    w0 = we_cnt;
    frame(8'h4C, 8'h00, 8'h00, 8'h00, r);
    chk("R10 mode left", 64'(we_cnt), 64'(w0));
    frame(8'hAC, 8'h53, 8'h00, 8'h00, r);
    chk("R10 realigned echo", 64'(r[15:8]), 64'h53);
    frame(8'h4C, 8'h00, 8'h00, 8'h00, r);
    chk("R3 partial load had no effect", cap_mask, 64'd0);
    chk("R3 strobe after realign", 64'(we_cnt), 64'(w0 + 1));

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule